// File: doc/BRIEF.md
# Ping-Pong DMA Page Controller

This block runs the two-page descriptor of one DMA channel that carries a byte stream from a channel buffer into system memory. Each page, ping (page 0) and pong (page 1), holds a byte base address, a depth field equal to the page length in bytes minus one, and four flags: packet-start, done, error and ready. Software arms a page by writing its control word with ready set and done and error cleared. The engine fills only the active page, and only while that page is ready and free of error.

Each accepted byte becomes one memory write request. The request carries the word-aligned address, a single byte enable and the byte placed on its lane. A channel bit chooses little-endian or big-endian lane order. When the last byte of a page is acknowledged, the engine marks the page done, withdraws its ready flag, raises a one-cycle interrupt request and switches the active-page bit itself. If the next page is not armed, the byte port applies backpressure until it is. An error response on a memory write marks the page in error and halts the channel until software arms that page again.

Top module: `dma_pingpong_ctl`

## Requirements
- R1: After reset all descriptor registers read zero, and in_ready, mem_req and irq are low.
- R2: Descriptor select 0 and 2 hold the base address of page 0 and page 1. Select 1 and 3 hold the page control word: depth in bits [10:0], packet-start in bit 16, done in bit 17, error in bit 18, ready in bit 19. Select 4 holds the channel word: active page in bit 0, big-endian in bit 1, enable in bit 2. Every field reads back as written until the hardware changes it.
- R3: in_ready is high only when the channel is enabled, the active page is ready and not in error, and no memory request is outstanding. A request stays asserted with a stable address until mem_ack.
- R4: Every accepted byte at page offset k produces exactly one request whose mem_addr is (base + k) with its two low bits cleared, and which has exactly one byte enable set.
- R5: With lane L = (base + k) mod 4, the enabled lane is L in little-endian mode and 3 - L in big-endian mode. mem_wdata carries the byte on that lane and zero on every other lane.
- R6: When the request for offset depth of the active page is acknowledged without error, that page's done bit is set, its ready bit is cleared, irq is high for exactly one cycle and the active-page bit toggles. The next byte goes to offset 0 of the other page.
- R7: If the newly active page is not ready, in_ready stays low and no request is made until software arms that page.
- R8: An acknowledgement with mem_err sets the error bit of the page, gives no irq, holds in_ready low, and restarts that page at offset 0 once software re-arms it.
- R9: mem_sop is high on the request for offset 0 of a page whose packet-start bit is set, and low on every other request.
- R10: A software write to the active-page bit selects the page that the next byte uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_sel | input | 3 | Descriptor register select |
| cfg_wdata | input | 32 | Descriptor write data |
| cfg_rdata | output | 32 | Descriptor read data for cfg_sel |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Byte stream ready (backpressure when low) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned write address |
| mem_wdata | output | 32 | Write data with the byte on its lane |
| mem_be | output | 4 | Byte enables, one lane set |
| mem_sop | output | 1 | Request starts a packet |
| mem_ack | input | 1 | Memory acknowledges the request |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 1 | One-cycle page-complete interrupt request |

## Verification
The bench sweeps both byte orders against every base-address misalignment and several page depths, and computes each request's address, lane and data from the base and the offset. A design with a misplaced lane mirror, or one that forgets to add the base, fails on the first misaligned page. Page lengths of depth plus one catch an off-by-one in the completion compare: the switch would come one byte early or late, and the irq and the active-bit readback would both be wrong. The bench also stalls on an unarmed pong page, injects an error response mid-page so that a design which advances the offset or fires irq on a failed write shows up, and overrides the active page from software.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
   localparam int SEL_W     = 3;
   localparam int CHAN_SEL  = 4;
   localparam int PS_BIT    = 16;
   localparam int DNE_BIT   = 17;
   localparam int ERR_BIT   = 18;
   localparam int RDY_BIT   = 19;
   localparam int ACT_BIT   = 0;
   localparam int BIGE_BIT  = 1;
   localparam int EN_BIT    = 2;

   typedef struct packed {
      logic ps;
      logic dne;
      logic err;
      logic rdy;
   } page_flags_t;
endpackage

// File: rtl/dma_pp_regs.sv
module dma_pp_regs
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DEPTH_W = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [SEL_W-1:0]              cfg_sel,
   input  logic [31:0]                   cfg_wdata,
   output logic [31:0]                   cfg_rdata,
   input  logic                          ev_done,
   input  logic                          ev_err,
   input  logic                          ev_page,
   output logic [1:0][ADDR_W-1:0]        base_o,
   output logic [1:0][DEPTH_W-1:0]       depth_o,
   output page_flags_t [1:0]             flags_o,
   output logic                          active_o,
   output logic                          big_o,
   output logic                          en_o
);
   initial begin
      assert (DEPTH_W >= 1 && DEPTH_W <= PS_BIT) else $error("depth field overlaps flags");
      assert (ADDR_W >= 2 && ADDR_W <= 32) else $error("address width out of range");
   end

   for (genvar p = 0; p < 2; p++) begin : g_page
      localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(2 * p);
      localparam logic [SEL_W-1:0] CTL_SEL  = SEL_W'(2 * p + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[p]  <= '0;
            depth_o[p] <= '0;
            flags_o[p] <= '0;
         end else begin
            if (cfg_we && cfg_sel == BASE_SEL)
               base_o[p] <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && cfg_sel == CTL_SEL) begin
               depth_o[p]     <= cfg_wdata[DEPTH_W-1:0];
               flags_o[p].ps  <= cfg_wdata[PS_BIT];
               flags_o[p].dne <= cfg_wdata[DNE_BIT];
               flags_o[p].err <= cfg_wdata[ERR_BIT];
               flags_o[p].rdy <= cfg_wdata[RDY_BIT];
            end
            if (ev_done && ev_page == 1'(p)) begin
               flags_o[p].dne <= 1'b1;
               flags_o[p].rdy <= 1'b0;
            end
            if (ev_err && ev_page == 1'(p))
               flags_o[p].err <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         big_o    <= 1'b0;
         en_o     <= 1'b0;
      end else begin
         if (cfg_we && cfg_sel == SEL_W'(CHAN_SEL)) begin
            active_o <= cfg_wdata[ACT_BIT];
            big_o    <= cfg_wdata[BIGE_BIT];
            en_o     <= cfg_wdata[EN_BIT];
         end
         if (ev_done)
            active_o <= ~active_o;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel == SEL_W'(CHAN_SEL)) begin
         cfg_rdata[ACT_BIT]  = active_o;
         cfg_rdata[BIGE_BIT] = big_o;
         cfg_rdata[EN_BIT]   = en_o;
      end else if (cfg_sel < SEL_W'(CHAN_SEL)) begin
         if (cfg_sel[0]) begin
            cfg_rdata[DEPTH_W-1:0] = depth_o[cfg_sel[1]];
            cfg_rdata[PS_BIT]      = flags_o[cfg_sel[1]].ps;
            cfg_rdata[DNE_BIT]     = flags_o[cfg_sel[1]].dne;
            cfg_rdata[ERR_BIT]     = flags_o[cfg_sel[1]].err;
            cfg_rdata[RDY_BIT]     = flags_o[cfg_sel[1]].rdy;
         end else begin
            cfg_rdata[ADDR_W-1:0]  = base_o[cfg_sel[1]];
         end
      end
   end

   // R6
   done_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> active_o != $past(active_o));

   // R6
   done_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> flags_o[$past(ev_page)].dne && !flags_o[$past(ev_page)].rdy);

   // R8
   err_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err |=> flags_o[$past(ev_page)].err);
endmodule

// File: rtl/dma_pp_lane.sv
module dma_pp_lane #(
   parameter int WORD_BYTES = 4,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int DATA_W    = 8 * WORD_BYTES
) (
   input  logic [LANE_W-1:0]     lo_addr,
   input  logic                  big_endian,
   input  logic [7:0]            byte_in,
   output logic [WORD_BYTES-1:0] be,
   output logic [DATA_W-1:0]     wdata
);
   initial begin
      assert (WORD_BYTES >= 2 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("word must be a power of two of at least two bytes");
   end

   logic [LANE_W-1:0] lane_sel;
   assign lane_sel = big_endian ? (LANE_W'(WORD_BYTES - 1) - lo_addr) : lo_addr;

   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      assign be[l]          = (lane_sel == LANE_W'(l));
      assign wdata[8*l +: 8] = be[l] ? byte_in : 8'h00;
   end
endmodule

// File: rtl/dma_pp_engine.sv
module dma_pp_engine
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DEPTH_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               act,
   input  logic [ADDR_W-1:0]  base,
   input  logic [DEPTH_W-1:0] depth,
   input  page_flags_t        flags,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   output logic               in_ready,
   input  logic               mem_ack,
   input  logic               mem_err,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [7:0]         req_byte,
   output logic               req_sop,
   output logic               ev_done,
   output logic               ev_err,
   output logic               ev_page,
   output logic               irq
);
   logic [DEPTH_W-1:0] off;
   logic               pend;
   logic               ack_ok;

   assign in_ready  = en && flags.rdy && !flags.err && !pend;
   assign req_valid = pend;
   assign ack_ok    = pend && mem_ack;
   assign ev_done   = ack_ok && !mem_err && (off == depth);
   assign ev_err    = ack_ok && mem_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off      <= '0;
         pend     <= 1'b0;
         req_addr <= '0;
         req_byte <= '0;
         req_sop  <= 1'b0;
         ev_page  <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= ev_done;
         if (in_valid && in_ready) begin
            pend     <= 1'b1;
            req_addr <= base + ADDR_W'(off);
            req_byte <= in_data;
            req_sop  <= flags.ps && (off == '0);
            ev_page  <= act;
         end else if (ack_ok) begin
            pend <= 1'b0;
            if (mem_err || off == depth) off <= '0;
            else                        off <= off + 1'b1;
         end
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mem_ack |=> req_valid && $stable(req_addr) && $stable(req_byte));

   // R3
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !in_ready);

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R8
   err_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err |=> !irq);
endmodule

// File: rtl/dma_pingpong_ctl.sv
module dma_pingpong_ctl
   import dma_pp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DEPTH_W    = 11,
   parameter int WORD_BYTES = 4,
   localparam int LANE_W    = $clog2(WORD_BYTES),
   localparam int DATA_W    = 8 * WORD_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [SEL_W-1:0]      cfg_sel,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic                  in_valid,
   input  logic [7:0]            in_data,
   output logic                  in_ready,
   output logic                  mem_req,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [WORD_BYTES-1:0] mem_be,
   output logic                  mem_sop,
   input  logic                  mem_ack,
   input  logic                  mem_err,
   output logic                  irq
);
   logic [1:0][ADDR_W-1:0]  base_w;
   logic [1:0][DEPTH_W-1:0] depth_w;
   page_flags_t [1:0]       flags_w;
   logic                    active_w, big_w, en_w;
   logic                    ev_done_w, ev_err_w, ev_page_w;
   logic [ADDR_W-1:0]       req_addr_w;
   logic [7:0]              req_byte_w;

   dma_pp_regs #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ev_done(ev_done_w), .ev_err(ev_err_w), .ev_page(ev_page_w),
      .base_o(base_w), .depth_o(depth_w), .flags_o(flags_w),
      .active_o(active_w), .big_o(big_w), .en_o(en_w)
   );

   dma_pp_engine #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) eng_i (
      .clk(clk), .rst_n(rst_n), .en(en_w), .act(active_w),
      .base(base_w[active_w]), .depth(depth_w[active_w]), .flags(flags_w[active_w]),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .mem_ack(mem_ack), .mem_err(mem_err),
      .req_valid(mem_req), .req_addr(req_addr_w), .req_byte(req_byte_w),
      .req_sop(mem_sop), .ev_done(ev_done_w), .ev_err(ev_err_w),
      .ev_page(ev_page_w), .irq(irq)
   );

   dma_pp_lane #(.WORD_BYTES(WORD_BYTES)) lane_i (
      .lo_addr(req_addr_w[LANE_W-1:0]), .big_endian(big_w),
      .byte_in(req_byte_w), .be(mem_be), .wdata(mem_wdata)
   );

   assign mem_addr = {req_addr_w[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

   // R4
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> $countones(mem_be) == 1);

   // R7
   stall_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req && !in_ready |=> !mem_req);
endmodule

// File: tb/dma_pingpong_ctl_tb.sv
`timescale 1ns/1ps
module dma_pingpong_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_sop;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic        irq;

   always #2 clk = ~clk;

   dma_pingpong_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_sop(mem_sop), .mem_ack(mem_ack),
      .mem_err(mem_err), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int unsigned m_base [2];
   int unsigned m_depth [2];
   bit          m_ps [2];
   int          m_pg = 0;
   int unsigned m_off = 0;
   bit          m_big = 1'b0;

   localparam int unsigned RDY = 32'h0008_0000;
   localparam int unsigned ERRF = 32'h0004_0000;
   localparam int unsigned DNE = 32'h0002_0000;
   localparam int unsigned PSF = 32'h0001_0000;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input int unsigned data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = data;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int sel, output logic [31:0] val);
      @(negedge clk);
      cfg_sel = 3'(sel);
      #1 val = cfg_rdata;
   endtask

   task automatic arm(input int p, input int unsigned base, input int unsigned depth, input bit ps);
      m_base[p] = base; m_depth[p] = depth; m_ps[p] = ps;
      wr(2 * p, base);
      wr(2 * p + 1, depth | (ps ? PSF : 0) | RDY);
   endtask

   task automatic send_byte(input logic [7:0] d, input bit inject_err);
      int unsigned a;
      int lane;
      bit exp_done;
      @(negedge clk);
      in_valid = 1'b1; in_data = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      a = m_base[m_pg] + m_off;
      lane = m_big ? 3 - int'(a % 4) : int'(a % 4);
      chk("R3 mem_req after accept", {31'b0, mem_req}, 32'd1);
      chk("R4 mem_addr", mem_addr, a & 32'hFFFF_FFFC);
      chk("R5 mem_be", {28'b0, mem_be}, 32'd1 << lane);
      chk("R5 mem_wdata", mem_wdata, {24'b0, d} << (8 * lane));
      chk("R9 mem_sop", {31'b0, mem_sop}, {31'b0, m_ps[m_pg] && m_off == 0});
      chk("R3 in_ready low while busy", {31'b0, in_ready}, 32'd0);
      mem_ack = 1'b1; mem_err = inject_err;
      exp_done = !inject_err && (m_off == m_depth[m_pg]);
      @(posedge clk);
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      chk(inject_err ? "R8 no irq on error" : "R6 irq pulse", {31'b0, irq}, {31'b0, exp_done});
      if (inject_err) m_off = 0;
      else if (exp_done) begin m_off = 0; m_pg = 1 - m_pg; end
      else m_off++;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 in_ready", {31'b0, in_ready}, 32'd0);
      chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      for (int s = 0; s < 5; s++) begin
         rd(s, v);
         chk("R1 register reset", v, 32'd0);
      end

      // Sweep: both byte orders, every base misalignment, varied depth.
      for (int e = 0; e < 2; e++) begin
         for (int bo = 0; bo < 4; bo++) begin
            arm(0, 32'h0000_1000 + bo, 4 + bo, 1'b1);
            arm(1, 32'h0000_2000 + 3 - bo, 4, 1'b0);
            wr(4, 4 | (e << 1));
            m_pg = 0; m_off = 0; m_big = e[0];
            rd(4, v);
            chk("R2 channel word", v, 4 | (e << 1));
            rd(0, v);
            chk("R2 ping base", v, m_base[0]);
            rd(1, v);
            chk("R2 ping control", v, m_depth[0] | PSF | RDY);
            for (int k = 0; k <= 4 + bo; k++) send_byte(8'(k * 7 + e + bo), 1'b0);
            rd(1, v);
            chk("R6 ping done", v, m_depth[0] | PSF | DNE);
            rd(4, v);
            chk("R6 active toggled", v, 5 | (e << 1));
            for (int k = 0; k <= 4; k++) send_byte(8'(8'hA0 + k), 1'b0);
            rd(3, v);
            chk("R6 pong done", v, 4 | DNE);
            rd(4, v);
            chk("R6 active back", v, 4 | (e << 1));
         end
      end

      // Stall on an unarmed next page.
      arm(0, 32'h0000_3000, 4, 1'b1);
      wr(3, 0);
      wr(4, 4);
      m_pg = 0; m_off = 0; m_big = 1'b0;
      for (int k = 0; k < 5; k++) send_byte(8'(k + 1), 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 stalled in_ready", {31'b0, in_ready}, 32'd0);
         chk("R7 stalled mem_req", {31'b0, mem_req}, 32'd0);
      end
      arm(1, 32'h0000_4002, 5, 1'b0);
      @(negedge clk);
      chk("R7 resume after arm", {31'b0, in_ready}, 32'd1);
      for (int k = 0; k < 6; k++) send_byte(8'(8'h50 + k), 1'b0);
      @(negedge clk);
      chk("R7 ping done not re-armed", {31'b0, in_ready}, 32'd0);

      // Error response mid-page.
      arm(0, 32'h0000_3001, 7, 1'b1);
      send_byte(8'h11, 1'b0);
      send_byte(8'h22, 1'b0);
      send_byte(8'h33, 1'b1);
      rd(1, v);
      chk("R8 error flag", v, 7 | PSF | RDY | ERRF);
      @(negedge clk);
      chk("R8 halted", {31'b0, in_ready}, 32'd0);
      arm(0, 32'h0000_3001, 7, 1'b1);
      for (int k = 0; k < 8; k++) send_byte(8'(8'hC0 + k), 1'b0);
      rd(4, v);
      chk("R6 active after ping", v, 5);

      // Software override of the active page.
      wr(4, 4);
      arm(0, 32'h0000_5003, 2, 1'b1);
      m_pg = 0; m_off = 0;
      for (int k = 0; k < 3; k++) send_byte(8'(8'hE0 + k), 1'b0);
      rd(4, v);
      chk("R10 software-selected page completed", v, 5);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule